// File: doc/BRIEF.md
# Per-Core Request Throttle Controller

This block limits how hard each core may push requests toward a shared memory system. Every core owns a three-bit throttle level. The level picks two limits at once: a cap on the requests the core may have in flight, and a minimum number of cycles between two injections. A core raises its request line when it wants to send. The block answers with a registered grant whenever both limits allow it. Each completion returned to the core lowers its in-flight count by one.

A separate estimator decides, once per interval, whether the system has become unfair. It supplies that verdict and names two cores: the most slowed-down one and the one hurting it most. On the interval pulse the block moves the interfering core one level more restrictive and the slowed core one level less restrictive. All other cores keep their levels. The new levels govern grants from the next cycle on.

Top module: `thr_throttle_ctrl`

## Requirements
- R1: After a synchronous reset every core sits at level code 0 (the least restrictive level), no grant is high and every in-flight count is zero.
- R2: Level codes 0 to 7 map to in-flight caps of 128, 64, 32, 12, 6, 5, 3, 2 and injection spacings of 1, 2, 4, 10, 20, 25, 30, 50 cycles, in that order. Level code c appears on `level_flat[3*c+2:3*c]` for core c.
- R3: A core is not granted while its in-flight count is at or above the cap of its current level.
- R4: Two grants to the same core are at least the spacing of its level apart, counted in clock cycles. With spacing 1 a core may be granted every cycle.
- R5: On a cycle with `ivl_tick` and `unfair_hi` high and `slow_idx` differing from `intf_idx`, the interfering core's level code rises by one and the slowest core's level code falls by one.
- R6: Levels change only on such a cycle. Cores not named keep their levels.
- R7: Level codes saturate: code 7 does not rise further and code 0 does not fall further.
- R8: When `slow_idx` equals `intf_idx`, an interval decision changes no level.
- R9: A grant adds one to the core's in-flight count and a completion subtracts one, both in the same cycle if they coincide. A completion at a count of zero is ignored.
- R10: The grant for a request sampled at a clock edge is visible after that edge. A level update made at an edge applies to the grant decisions of the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CORES | Per-core request wanting injection |
| cpl | input | NUM_CORES | Per-core completion of one in-flight request |
| ivl_tick | input | 1 | Interval boundary pulse |
| unfair_hi | input | 1 | Estimated unfairness is above target |
| slow_idx | input | IDX_W | Index of the most slowed-down core |
| intf_idx | input | IDX_W | Index of the core interfering most with it |
| grant | output | NUM_CORES | Registered per-core injection grant |
| level_flat | output | 3*NUM_CORES | Current level code of every core, three bits each |

## Verification
Each grant is due one edge after the inputs that produced it are sampled. A level written at an interval pulse is seen on `level_flat` after that same edge and first gates grants one edge later. The bench drives each vector just after a falling edge. It pushes the outcome that its own reference model predicts into a queue. A monitor pops that entry a nanosecond after the next rising edge, so every comparison lines up with exactly one register stage. Directed phases hold the quota stop at levels 3 and 7, the 50-cycle spacing, saturation, coinciding grant and completion, and equal indices. A long random phase then mixes all of these.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int LVL_W   = 3;
  localparam int QUOTA_W = 8;
  localparam int GAP_W   = 6;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_OPEN  = lvl_t'(0);
  localparam lvl_t LVL_TIGHT = lvl_t'(7);
endpackage

// File: rtl/thr_level_table.sv
module thr_level_table
  import thr_pkg::*;
(
  input  lvl_t               code,
  output logic [QUOTA_W-1:0] quota,
  output logic [GAP_W-1:0]   gap
);
  // Decode of one level code into its in-flight cap and injection spacing.
  always_comb begin
    case (code)
      3'd0: begin quota = 8'd128; gap = 6'd1;  end
      3'd1: begin quota = 8'd64;  gap = 6'd2;  end
      3'd2: begin quota = 8'd32;  gap = 6'd4;  end
      3'd3: begin quota = 8'd12;  gap = 6'd10; end
      3'd4: begin quota = 8'd6;   gap = 6'd20; end
      3'd5: begin quota = 8'd5;   gap = 6'd25; end
      3'd6: begin quota = 8'd3;   gap = 6'd30; end
      default: begin quota = 8'd2; gap = 6'd50; end
    endcase
  end
endmodule

// File: rtl/thr_core_lane.sv
module thr_core_lane
  import thr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic cpl,
  input  lvl_t lvl,
  output logic grant_q
);
  localparam logic [GAP_W-1:0] GAP_SAT = {GAP_W{1'b1}};

  logic [QUOTA_W-1:0] quota;
  logic [GAP_W-1:0]   gap;
  logic [CNT_W-1:0]   out_q;
  logic [GAP_W-1:0]   since_q;
  logic               grant_d;
  logic               dec;
  logic               past_ok;

  thr_level_table tbl_i (
    .code  (lvl),
    .quota (quota),
    .gap   (gap)
  );

  always_comb begin
    grant_d = req && (CNT_W'(quota) > out_q) && (since_q >= gap);
    dec     = cpl && (out_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      since_q <= GAP_SAT;
      grant_q <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      grant_q <= grant_d;
      out_q   <= out_q + CNT_W'(grant_d) - CNT_W'(dec);
      if (grant_d)
        since_q <= GAP_W'(1);
      else if (since_q != GAP_SAT)
        since_q <= since_q + GAP_W'(1);
    end
  end

  // R3: a grant only leaves a count below the cap seen when it was decided
  a_r3_under_cap: assert property (@(posedge clk) disable iff (rst || !past_ok)
    grant_q |-> ($past(out_q) < CNT_W'($past(quota))));

  // R4: back-to-back grants only at the fastest spacing
  a_r4_spacing: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (grant_q && $past(grant_q)) |-> ($past(gap) == GAP_W'(1)));

  // R9: an idle lane with nothing in flight stays empty despite completions
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(out_q) == '0 && !grant_q) |-> (out_q == '0));
endmodule

// File: rtl/thr_level_ctrl.sv
module thr_level_ctrl
  import thr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ivl_tick,
  input  logic                           unfair_hi,
  input  logic [IDX_W-1:0]               slow_idx,
  input  logic [IDX_W-1:0]               intf_idx,
  output logic [NUM_CORES-1:0][LVL_W-1:0] lvl_q
);
  logic apply;
  logic past_ok;

  assign apply = ivl_tick && unfair_hi && (slow_idx != intf_idx);

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[c] <= LVL_OPEN;
      end else if (apply) begin
        if (intf_idx == IDX_W'(c) && lvl_q[c] != LVL_TIGHT)
          lvl_q[c] <= lvl_q[c] + lvl_t'(1);
        else if (slow_idx == IDX_W'(c) && lvl_q[c] != LVL_OPEN)
          lvl_q[c] <= lvl_q[c] - lvl_t'(1);
      end
    end

    // R5: a level only tightens when this core was named as the interferer
    a_r5_tighten_named: assert property (@(posedge clk) disable iff (rst || !past_ok)
      (lvl_q[c] > $past(lvl_q[c])) |-> ($past(apply) && $past(intf_idx) == IDX_W'(c)));

    // R7: at the loosest level a slowest-core decision leaves the code at 0
    a_r7_floor: assert property (@(posedge clk) disable iff (rst || !past_ok)
      (apply && slow_idx == IDX_W'(c) && lvl_q[c] == LVL_OPEN) |=> (lvl_q[c] == LVL_OPEN));
  end

  // R6: no interval decision, no level movement
  a_r6_hold: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !(ivl_tick && unfair_hi) |=> $stable(lvl_q));

  // R8: equal indices make the decision void
  a_r8_same_idx: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (ivl_tick && slow_idx == intf_idx) |=> $stable(lvl_q));
endmodule

// File: rtl/thr_throttle_ctrl.sv
module thr_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8,
  parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CORES-1:0]       req_valid,
  input  logic [NUM_CORES-1:0]       cpl,
  input  logic                       ivl_tick,
  input  logic                       unfair_hi,
  input  logic [IDX_W-1:0]           slow_idx,
  input  logic [IDX_W-1:0]           intf_idx,
  output logic [NUM_CORES-1:0]       grant,
  output logic [LVL_W*NUM_CORES-1:0] level_flat
);
  logic [NUM_CORES-1:0][LVL_W-1:0] lvl_q;

  thr_level_ctrl #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .ivl_tick  (ivl_tick),
    .unfair_hi (unfair_hi),
    .slow_idx  (slow_idx),
    .intf_idx  (intf_idx),
    .lvl_q     (lvl_q)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
    thr_core_lane #(
      .CNT_W (CNT_W)
    ) lane_i (
      .clk     (clk),
      .rst     (rst),
      .req     (req_valid[c]),
      .cpl     (cpl[c]),
      .lvl     (lvl_q[c]),
      .grant_q (grant[c])
    );
  end

  assign level_flat = lvl_q;
endmodule

// File: tb/thr_throttle_ctrl_tb_top.sv
`timescale 1ns/1ps
module thr_throttle_ctrl_tb_top;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_valid = '0;
  logic [N-1:0]  cpl = '0;
  logic          ivl_tick = 1'b0;
  logic          unfair_hi = 1'b0;
  logic [1:0]    slow_idx = '0;
  logic [1:0]    intf_idx = '0;
  logic [N-1:0]  grant;
  logic [3*N-1:0] level_flat;

  int vectors = 0;
  int fails   = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  thr_throttle_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .cpl        (cpl),
    .ivl_tick   (ivl_tick),
    .unfair_hi  (unfair_hi),
    .slow_idx   (slow_idx),
    .intf_idx   (intf_idx),
    .grant      (grant),
    .level_flat (level_flat)
  );

  typedef struct {
    logic [N-1:0]   g;
    logic [3*N-1:0] l;
    string          tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference model state, built from the requirement text only
  int lv [N];
  int ofl[N];
  int since[N];

  function automatic int cap_of(input int l);
    case (l)
      0: return 128; 1: return 64; 2: return 32; 3: return 12;
      4: return 6;   5: return 5;  6: return 3;  default: return 2;
    endcase
  endfunction

  function automatic int gap_of(input int l);
    case (l)
      0: return 1;  1: return 2;  2: return 4;  3: return 10;
      4: return 20; 5: return 25; 6: return 30; default: return 50;
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      lv[c] = 0; ofl[c] = 0; since[c] = 63;
    end
  endtask

  // Driver: drive one vector after a falling edge and queue the predicted result
  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] cp,
                      input logic tk, input logic un,
                      input int sl, input int it, input string tag);
    exp_t e;
    req_valid = rq; cpl = cp; ivl_tick = tk; unfair_hi = un;
    slow_idx = 2'(sl); intf_idx = 2'(it);
    for (int c = 0; c < N; c++) begin
      e.g[c] = rq[c] && (ofl[c] < cap_of(lv[c])) && (since[c] >= gap_of(lv[c]));
      if (cp[c] && ofl[c] > 0) ofl[c]--;
      if (e.g[c]) begin ofl[c]++; since[c] = 1; end
      else if (since[c] < 63) since[c]++;
    end
    if (tk && un && sl != it) begin
      if (lv[it] < 7) lv[it]++;
      if (lv[sl] > 0) lv[sl]--;
    end
    for (int c = 0; c < N; c++) e.l[3*c +: 3] = 3'(lv[c]);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare one register stage after each driven vector
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      vectors++;
      if (grant !== e.g) begin
        fails++;
        $display("FAIL %s grant: actual %b expected %b at %0t", e.tag, grant, e.g, $time);
      end
      vectors++;
      if (level_flat !== e.l) begin
        fails++;
        $display("FAIL %s levels: actual %h expected %h at %0t", e.tag, level_flat, e.l, $time);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    vectors++;
    if (grant !== '0 || level_flat !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual %b/%h expected 0/0", grant, level_flat);
    end

    // R4 and R10: open level grants every cycle, one edge after request
    for (int i = 0; i < 6; i++) step(4'hF, 4'h0, 0, 0, 0, 0, "R4");
    // R9: grant and completion in the same cycle
    for (int i = 0; i < 4; i++) step(4'hF, 4'hF, 0, 0, 0, 0, "R9");
    // R9: drain, last completions arrive with nothing in flight
    for (int i = 0; i < 8; i++) step(4'h0, 4'hF, 0, 0, 0, 0, "R9");

    // R5 and R7: tighten core 1 to the limit while core 0 stays open
    for (int i = 0; i < 9; i++) step(4'h0, 4'h0, 1, 1, 0, 1, "R7");
    // R8: equal indices
    step(4'h0, 4'h0, 1, 1, 2, 2, "R8");
    // R6: tick without unfairness, unfairness without tick
    step(4'h0, 4'h0, 1, 0, 1, 0, "R6");
    step(4'h0, 4'h0, 0, 1, 1, 0, "R6");

    // R3 and R4: tightest level, 50-cycle spacing, cap of 2
    for (int i = 0; i < 160; i++) step(4'h2, 4'h0, 0, 0, 0, 0, "R3");
    step(4'h2, 4'h2, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 10; i++) step(4'h2, 4'h0, 0, 0, 0, 0, "R3");

    // R5 and R10: core 2 to level code 3, requesting at once
    for (int i = 0; i < 3; i++) step(4'h4, 4'h0, 1, 1, 3, 2, "R10");
    // R3: cap of 12 with spacing 10
    for (int i = 0; i < 150; i++) step(4'h4, 4'h0, 0, 0, 0, 0, "R3");
    // R5: loosen core 1 one step at a time
    for (int i = 0; i < 3; i++) step(4'h2, 4'h2, 1, 1, 1, 3, "R5");

    // R2: mixed random traffic across all levels
    for (int i = 0; i < 3000; i++) begin
      logic tk;
      tk = (i % 37) == 36;
      step(4'($urandom), 4'($urandom), tk, 1'($urandom),
           int'($urandom % 4), int'($urandom % 4), "R2");
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule